// File: doc/BRIEF.md
# Write-Buffer Read-After-Write Hazard Detector

This block sits inside a bus-to-memory bridge whose write path acknowledges writes before memory has absorbed them. It keeps the region tag of each accepted write that has not yet completed. Each incoming read is tested against those tags, and the read is held back while any of them could conflict with it. Without this check, a read could return data from before the most recent write to the same location.

The comparison is deliberately coarse. Two addresses conflict when they fall in the same 4 KB region, which means that all address bits from bit 12 upward are equal. The only remedy is to stall: no data is ever forwarded from the buffer. Writes complete in the order in which they were accepted, so the tag store is a small FIFO with one valid bit per slot. When every slot is occupied, a full flag tells the bridge to stop accepting writes.

Top module: `raw_hazard_detector`

## Requirements
- R1: Out of reset no write is outstanding, `rd_stall` is low and `buf_full` is low.
- R2: While `rd_req` is high, `rd_stall` is high in that same cycle whenever `rd_addr[ADDR_W-1:12]` equals the region of any outstanding write. Bits 11:0 play no part in the comparison.
- R3: A read whose region matches no outstanding write sees `rd_stall` low in the same cycle, so it incurs no added stall cycle.
- R4: At most DEPTH (default 4) writes are outstanding. `buf_full` is high in the cycle after a clock edge that leaves DEPTH writes outstanding. A `wr_accept` presented while `buf_full` is high is ignored, and its region never causes a stall.
- R5: A `wr_done` pulse retires the oldest outstanding write, so writes leave in the order in which they were accepted.
- R6: When `wr_done` is high in the same cycle that a read is checked, the oldest entry (the one retiring) is left out of the comparison.
- R7: A `wr_done` pulse while no write is outstanding is ignored. A write accepted afterwards is still tracked.
- R8: A write accepted in the same cycle as a read is not compared against that read. It joins the comparison from the next cycle.
- R9: `rd_stall` is low in every cycle in which `rd_req` is low.
- R10: An accept and a retire in the same cycle leave the number of outstanding writes unchanged, provided the buffer is not full. If the buffer is full, only the retire takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_accept | input | 1 | One write is accepted into the buffer this cycle |
| wr_addr | input | ADDR_W | Byte address of the accepted write |
| wr_done | input | 1 | The oldest buffered write has reached memory |
| rd_req | input | 1 | A read wants to issue this cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_stall | output | 1 | Hold the read: it conflicts with a buffered write |
| buf_full | output | 1 | All slots are in use; further writes must wait |

## Verification
The hardest case to reach is a full buffer in which one cycle combines a completion, a new write and a read that matches only the retiring head entry. All three inputs must line up exactly when the FIFO wraps. A directed sequence first fills the buffer with distinct regions and then drives that cycle deliberately. The random phase draws read and write addresses from only eight regions, with random low bits, so that matches, full conditions and simultaneous accept/retire cycles occur often. A bench FIFO model provides the expected value for every cycle.

// File: rtl/raw_hz_pkg.sv
package raw_hz_pkg;

  // Action applied to the tag FIFO in one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_REGION_LSB = 12;
  localparam int DEF_DEPTH      = 4;

endpackage

// File: rtl/raw_tag_fifo.sv
module raw_tag_fifo
  import raw_hz_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  fifo_op_e               op,
  input  logic [TAG_W-1:0]       push_tag,
  output logic [DEPTH*TAG_W-1:0] tags_flat,
  output logic [DEPTH-1:0]       slot_valid,
  output logic [PTR_W-1:0]       head_idx,
  output logic                   full,
  output logic                   empty
);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q, count_d;
  logic [DEPTH-1:0] valid_q;
  logic             full_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = (op == OP_PUSH) || (op == OP_BOTH);
  assign do_pop  = (op == OP_POP)  || (op == OP_BOTH);

  always_comb begin
    count_d = count_q;
    if (do_push && !do_pop) count_d = count_q + 1'b1;
    if (do_pop && !do_push) count_d = count_q - 1'b1;
  end

  // Tag storage: single write port, no reset.
  always_ff @(posedge clk) begin
    if (do_push) mem[tail_q] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      valid_q <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
    end else begin
      if (do_push) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= wrap_inc(tail_q);
      end
      if (do_pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= wrap_inc(head_q);
      end
      count_q <= count_d;
      full_q  <= (count_d == CNT_W'(DEPTH));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign tags_flat[g*TAG_W +: TAG_W] = mem[g];
  end

  assign slot_valid = valid_q;
  assign head_idx   = head_q;
  assign full       = full_q;
  assign empty      = (count_q == '0);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  a_r5_valid_matches_count: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) == int'(count_q));

  a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
    full_q && !do_pop |=> full_q);

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    full_q |-> !do_push);

  a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> !do_pop);

endmodule

// File: rtl/raw_region_cmp.sv
module raw_region_cmp #(
  parameter int TAG_W = 20,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH*TAG_W-1:0] tags_flat,
  input  logic [DEPTH-1:0]       slot_valid,
  input  logic [PTR_W-1:0]       head_idx,
  input  logic                   retiring,
  input  logic [TAG_W-1:0]       probe_tag,
  output logic                   hit
);

  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic excluded;
    assign excluded = retiring && (head_idx == PTR_W'(g));
    assign match[g] = slot_valid[g] && !excluded &&
                      (tags_flat[g*TAG_W +: TAG_W] == probe_tag);
  end

  assign hit = |match;

endmodule

// File: rtl/raw_hazard_detector.sv
module raw_hazard_detector
  import raw_hz_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int REGION_LSB = DEF_REGION_LSB,
  parameter int DEPTH      = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_done,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_stall,
  output logic              buf_full
);

  localparam int TAG_W = ADDR_W - REGION_LSB;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH*TAG_W-1:0] tags_flat;
  logic [DEPTH-1:0]       slot_valid;
  logic [PTR_W-1:0]       head_idx;
  logic                   full, empty;
  logic                   push, pop, hit;
  fifo_op_e               op;

  assign push = wr_accept && !full;
  assign pop  = wr_done && !empty;

  always_comb begin
    unique case ({pop, push})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_BOTH;
      default: op = OP_IDLE;
    endcase
  end

  raw_tag_fifo #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .push_tag   (wr_addr[ADDR_W-1:REGION_LSB]),
    .tags_flat  (tags_flat),
    .slot_valid (slot_valid),
    .head_idx   (head_idx),
    .full       (full),
    .empty      (empty)
  );

  raw_region_cmp #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_cmp (
    .tags_flat  (tags_flat),
    .slot_valid (slot_valid),
    .head_idx   (head_idx),
    .retiring   (pop),
    .probe_tag  (rd_addr[ADDR_W-1:REGION_LSB]),
    .hit        (hit)
  );

  assign rd_stall = rd_req && hit;
  assign buf_full = full;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot_valid == '0) && !buf_full);

  a_r9_stall_needs_req: assert property (@(posedge clk) disable iff (rst)
    !rd_req |-> !rd_stall);

  a_r6_sole_retiring_no_stall: assert property (@(posedge clk) disable iff (rst)
    ($countones(slot_valid) == 1) && wr_done && rd_req |-> !rd_stall);

  a_r3_empty_no_stall: assert property (@(posedge clk) disable iff (rst)
    (slot_valid == '0) |-> !rd_stall);

  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
    wr_accept && wr_done && !buf_full && (slot_valid != '0)
    |=> $countones(slot_valid) == $countones($past(slot_valid)));

endmodule

// File: tb/sim_raw_hazard_detector.sv
module sim_raw_hazard_detector;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_accept, wr_done, rd_req;
  logic [31:0] wr_addr, rd_addr;
  logic        rd_stall, buf_full;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [19:0] mq [4];
  int          mcnt = 0;

  always #2.5 clk = ~clk;

  raw_hazard_detector u0 (
    .clk(clk), .rst(rst), .wr_accept(wr_accept), .wr_addr(wr_addr),
    .wr_done(wr_done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_stall(rd_stall), .buf_full(buf_full)
  );

  function automatic logic [19:0] region(input logic [31:0] a);
    return a[31:12];
  endfunction

  function automatic logic exp_stall(input logic r, input logic [31:0] ra,
                                     input logic d);
    logic s = 1'b0;
    if (!r) return 1'b0;
    for (int i = 0; i < mcnt; i++) begin
      if (!(i == 0 && d) && mq[i] == region(ra)) s = 1'b1;
    end
    return s;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic [31:0] aa, input logic d,
                      input logic r, input logic [31:0] ra, input string req);
    logic push, pop;
    @(negedge clk);
    wr_accept = a; wr_addr = aa; wr_done = d; rd_req = r; rd_addr = ra;
    #1;
    check(rd_stall, exp_stall(r, ra, d), req);
    check(buf_full, mcnt == 4, {req, " full flag R4"});
    @(posedge clk);
    pop  = d && (mcnt > 0);
    push = a && (mcnt < 4);
    if (pop) begin
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (push) begin
      mq[mcnt] = region(aa);
      mcnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; wr_accept = 0; wr_done = 0; rd_req = 0;
    wr_addr = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: clean state after reset
    step(0, 0, 0, 1, 32'h1000_0000, "R1 reset");
    // R8: write accepted with a read to the same region in the same cycle
    step(1, 32'h1000_0010, 0, 1, 32'h1000_0FF0, "R8 same-cycle accept");
    step(1, 32'h1000_1000, 0, 1, 32'h1000_0004, "R2 region hit");
    step(1, 32'h2000_0000, 0, 0, 32'h1000_0004, "R9 no request");
    step(1, 32'h1000_2000, 0, 1, 32'h1000_3000, "R3 region miss");
    // full now: R4 accept ignored, then proven absent
    step(1, 32'h3000_0000, 0, 1, 32'h2000_0FFF, "R4 full R2 hit");
    step(0, 0, 0, 1, 32'h3000_0ABC, "R4 ignored write absent");
    // R6: retiring head excluded; R5 next oldest stays
    step(0, 0, 1, 1, 32'h1000_0000, "R6 retiring excluded");
    step(0, 0, 0, 1, 32'h1000_1FFF, "R5 in-order retire");
    // R10 swap not full, then fill and swap while full
    step(1, 32'h5000_0000, 1, 1, 32'h5000_0000, "R10 swap");
    step(1, 32'h6000_0000, 0, 1, 32'h2000_0000, "R5 order");
    step(1, 32'h7000_0000, 1, 1, 32'h2000_0000, "R10 full swap R6");
    step(0, 0, 0, 1, 32'h7000_0000, "R10 blocked write absent");
    // drain, then R7 retire on empty
    for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 32'h6000_0000, "R5 drain");
    step(0, 0, 1, 1, 32'h5000_0000, "R7 empty retire");
    step(1, 32'h8000_0000, 1, 0, 0, "R7 retire ignored");
    step(0, 0, 0, 1, 32'h8000_0FFF, "R7 write tracked R2");
    step(0, 0, 1, 0, 0, "R5 drain");

    for (int n = 0; n < 600; n++) begin
      logic a, d, r;
      logic [31:0] wa, ra;
      a  = ($urandom % 100) < 50;
      d  = ($urandom % 100) < 35;
      r  = ($urandom % 100) < 60;
      wa = 32'h4000_0000 + ((($urandom % 8)) << 12) + ($urandom & 32'hFFF);
      ra = 32'h4000_0000 + ((($urandom % 8)) << 12) + ($urandom & 32'hFFF);
      step(a, wa, d, r, ra, "R2/R3 random");
    end

    // R1: reset mid-traffic
    @(negedge clk); rst = 1'b1; wr_accept = 0; wr_done = 0; rd_req = 0;
    @(posedge clk); mcnt = 0;
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 1, 32'h4000_0000, "R1 second reset");

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule